// File: doc/BRIEF.md
# Page-Map Address Translator

This block turns each virtual address issued by a processor into a physical address by indexing an on-chip page map. For every virtual page the map keeps four separate arrays: a resident flag, a modified (dirty) flag, a physical page number and the location of the page's copy in secondary storage. Addresses are 12 bits wide: the upper 4 bits (`req_va[11:8]`) select one of 16 virtual pages and the lower 8 bits are the byte offset within a 256-byte page. Physical addresses are 11 bits: a 3-bit physical page number above the unchanged 8-bit offset.

Requests arrive on a valid/ready channel. `req_ready` reflects whether the page named by `req_va` is resident. A request is accepted in a cycle where both `req_valid` and `req_ready` are high, and `pa_o` holds its physical address in that same cycle. If the page is not resident, `req_ready` stays low and the request is held off. The requester must keep `req_valid`, `req_va` and `req_store` steady until acceptance or until it abandons the access. One cycle after a held-off request, `fault_o` rises. It reports the faulting page and its storage location so that a handler can bring the page in.

The handler uses a separate update port to rewrite one map entry per cycle, and an inspect port to read any entry, for example to find a dirty victim. Once the entry is resident, the request that is still pending is accepted, which models the retry of the faulting instruction. An accepted store marks its page dirty.

Top module: `page_map_xlate`

## Requirements
- R1: After reset every entry reads non-resident and clean with physical page 0 and storage address 0, and `fault_o` is 0.
- R2: When `req_valid` is high and the addressed page is not resident, `req_ready` is 0 in that cycle. On the next cycle `fault_o` is 1, `fault_vpn_o` equals `req_va[11:8]` of that request, and `fault_dadr_o` equals that entry's storage address.
- R3: When the addressed page is resident, `req_ready` is 1 and `pa_o` equals `{ppn, req_va[7:0]}` in the same cycle.
- R4: An accepted store (`req_store`=1) sets its page's dirty flag, seen from the next cycle on. An accepted load leaves the dirty flag unchanged.
- R5: A store that is held off by a fault does not change any dirty flag.
- R6: With `upd_en`=1, the resident, dirty, physical page and storage fields of entry `upd_vpn` are all written at the clock edge. A lookup of the same entry in that cycle still sees the old values.
- R7: If an update and an accepted store hit the same entry in one cycle, the update's dirty value is kept.
- R8: `fault_o` is 0 in any cycle that follows a cycle without a held-off request. A pending request is accepted in the first cycle after its entry has been made resident.
- R9: An update and an accepted store to different entries in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Addressed page is resident; request accepted when valid |
| req_va | input | 12 | Virtual address: page [11:8], offset [7:0] |
| req_store | input | 1 | 1 = store, 0 = load |
| pa_o | output | 11 | Physical address {ppn, offset} |
| fault_o | output | 1 | Registered page-fault flag |
| fault_vpn_o | output | 4 | Virtual page of the last fault |
| fault_dadr_o | output | 16 | Storage address of the last faulting page |
| upd_en | input | 1 | Write one map entry |
| upd_vpn | input | 4 | Entry to write |
| upd_resident | input | 1 | New resident flag |
| upd_dirty | input | 1 | New dirty flag |
| upd_ppn | input | 3 | New physical page number |
| upd_dadr | input | 16 | New storage address |
| insp_vpn | input | 4 | Entry to inspect |
| insp_resident | output | 1 | Inspected resident flag |
| insp_dirty | output | 1 | Inspected dirty flag |
| insp_ppn | output | 3 | Inspected physical page number |
| insp_dadr | output | 16 | Inspected storage address |

## Verification
Two things can land on the same entry in one cycle: the dirty mark from an accepted store and a handler rewrite through the update port. The bench provokes this by driving a store to page 3 in the very cycle that an update rewrites page 3 with a clean flag and a new frame. It then judges the outcome on the inspect port, where the entry must be clean and show the new frame. The translation in that cycle must still use the old frame. A second case pairs a store with an update to a different page in one cycle and expects both effects. A third case holds a faulting store pending while the update makes its page resident, and expects acceptance exactly one cycle later with the new frame.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int PMT_VPN_W  = 4;
  localparam int PMT_OFF_W  = 8;
  localparam int PMT_PPN_W  = 3;
  localparam int PMT_DADR_W = 16;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_MISS = 2'd2
  } lk_state_e;
endpackage

// File: rtl/pmt_map_store.sv
module pmt_map_store #(
  parameter int VPN_W  = 4,
  parameter int PPN_W  = 3,
  parameter int DADR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // handler write
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic              wr_res,
  input  logic              wr_dirty,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [DADR_W-1:0] wr_dadr,
  // dirty mark from accepted store
  input  logic              mark_en,
  input  logic [VPN_W-1:0]  mark_vpn,
  // lookup read port
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_res,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [DADR_W-1:0] lk_dadr,
  // inspect read port
  input  logic [VPN_W-1:0]  in_vpn,
  output logic              in_res,
  output logic              in_dirty,
  output logic [PPN_W-1:0]  in_ppn,
  output logic [DADR_W-1:0] in_dadr,
  // flag vectors
  output logic [(1<<VPN_W)-1:0] res_vec,
  output logic [(1<<VPN_W)-1:0] dirty_vec
);
  localparam int PAGES = 1 << VPN_W;

  logic [PPN_W-1:0]  ppn_arr  [PAGES];
  logic [DADR_W-1:0] dadr_arr [PAGES];

  for (genvar g = 0; g < PAGES; g++) begin : g_ent
    logic              sel_wr;
    logic              sel_mark;
    logic              r_q;
    logic              d_q;
    logic [PPN_W-1:0]  p_q;
    logic [DADR_W-1:0] a_q;

    assign sel_wr   = wr_en   && (wr_vpn   == VPN_W'(g));
    assign sel_mark = mark_en && (mark_vpn == VPN_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= 1'b0;
        d_q <= 1'b0;
        p_q <= '0;
        a_q <= '0;
      end else if (sel_wr) begin
        r_q <= wr_res;
        d_q <= wr_dirty;
        p_q <= wr_ppn;
        a_q <= wr_dadr;
      end else if (sel_mark) begin
        d_q <= 1'b1;
      end
    end

    assign res_vec[g]   = r_q;
    assign dirty_vec[g] = d_q;
    assign ppn_arr[g]   = p_q;
    assign dadr_arr[g]  = a_q;
  end

  assign lk_res   = res_vec[lk_vpn];
  assign lk_ppn   = ppn_arr[lk_vpn];
  assign lk_dadr  = dadr_arr[lk_vpn];

  assign in_res   = res_vec[in_vpn];
  assign in_dirty = dirty_vec[in_vpn];
  assign in_ppn   = ppn_arr[in_vpn];
  assign in_dadr  = dadr_arr[in_vpn];
endmodule

// File: rtl/pmt_lookup.sv
module pmt_lookup
  import pmt_pkg::*;
#(
  parameter int VPN_W  = 4,
  parameter int OFF_W  = 8,
  parameter int PPN_W  = 3,
  parameter int DADR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [VPN_W+OFF_W-1:0]  req_va,
  input  logic                    req_store,
  output logic [VPN_W-1:0]        ent_vpn,
  input  logic                    ent_res,
  input  logic [PPN_W-1:0]        ent_ppn,
  input  logic [DADR_W-1:0]       ent_dadr,
  output logic                    req_ready,
  output logic [PPN_W+OFF_W-1:0]  pa,
  output logic                    mark_en,
  output logic [VPN_W-1:0]        mark_vpn,
  output logic                    fault,
  output logic [VPN_W-1:0]        fault_vpn,
  output logic [DADR_W-1:0]       fault_dadr
);
  localparam int VA_W = VPN_W + OFF_W;

  lk_state_e          st;
  logic               fault_q;
  logic [VPN_W-1:0]   fvpn_q;
  logic [DADR_W-1:0]  fdadr_q;

  assign ent_vpn = req_va[VA_W-1:OFF_W];

  always_comb begin
    if (!req_valid)   st = LK_IDLE;
    else if (ent_res) st = LK_HIT;
    else              st = LK_MISS;
  end

  assign req_ready = ent_res;
  assign pa        = {ent_ppn, req_va[OFF_W-1:0]};
  assign mark_en   = (st == LK_HIT) && req_store;
  assign mark_vpn  = ent_vpn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      fvpn_q  <= '0;
      fdadr_q <= '0;
    end else begin
      fault_q <= (st == LK_MISS);
      if (st == LK_MISS) begin
        fvpn_q  <= ent_vpn;
        fdadr_q <= ent_dadr;
      end
    end
  end

  assign fault      = fault_q;
  assign fault_vpn  = fvpn_q;
  assign fault_dadr = fdadr_q;
endmodule

// File: rtl/page_map_xlate.sv
module page_map_xlate
  import pmt_pkg::*;
#(
  parameter int VPN_W  = PMT_VPN_W,
  parameter int OFF_W  = PMT_OFF_W,
  parameter int PPN_W  = PMT_PPN_W,
  parameter int DADR_W = PMT_DADR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W+OFF_W-1:0] req_va,
  input  logic                   req_store,
  output logic [PPN_W+OFF_W-1:0] pa_o,
  output logic                   fault_o,
  output logic [VPN_W-1:0]       fault_vpn_o,
  output logic [DADR_W-1:0]      fault_dadr_o,
  input  logic                   upd_en,
  input  logic [VPN_W-1:0]       upd_vpn,
  input  logic                   upd_resident,
  input  logic                   upd_dirty,
  input  logic [PPN_W-1:0]       upd_ppn,
  input  logic [DADR_W-1:0]      upd_dadr,
  input  logic [VPN_W-1:0]       insp_vpn,
  output logic                   insp_resident,
  output logic                   insp_dirty,
  output logic [PPN_W-1:0]       insp_ppn,
  output logic [DADR_W-1:0]      insp_dadr
);
  localparam int PAGES = 1 << VPN_W;

  logic [VPN_W-1:0]  lk_vpn;
  logic              lk_res;
  logic [PPN_W-1:0]  lk_ppn;
  logic [DADR_W-1:0] lk_dadr;
  logic              mark_en;
  logic [VPN_W-1:0]  mark_vpn;
  logic [PAGES-1:0]  resident_vec;
  logic [PAGES-1:0]  dirty_vec;

  pmt_map_store #(
    .VPN_W (VPN_W),
    .PPN_W (PPN_W),
    .DADR_W(DADR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (upd_en),
    .wr_vpn   (upd_vpn),
    .wr_res   (upd_resident),
    .wr_dirty (upd_dirty),
    .wr_ppn   (upd_ppn),
    .wr_dadr  (upd_dadr),
    .mark_en  (mark_en),
    .mark_vpn (mark_vpn),
    .lk_vpn   (lk_vpn),
    .lk_res   (lk_res),
    .lk_ppn   (lk_ppn),
    .lk_dadr  (lk_dadr),
    .in_vpn   (insp_vpn),
    .in_res   (insp_resident),
    .in_dirty (insp_dirty),
    .in_ppn   (insp_ppn),
    .in_dadr  (insp_dadr),
    .res_vec  (resident_vec),
    .dirty_vec(dirty_vec)
  );

  pmt_lookup #(
    .VPN_W (VPN_W),
    .OFF_W (OFF_W),
    .PPN_W (PPN_W),
    .DADR_W(DADR_W)
  ) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_va    (req_va),
    .req_store (req_store),
    .ent_vpn   (lk_vpn),
    .ent_res   (lk_res),
    .ent_ppn   (lk_ppn),
    .ent_dadr  (lk_dadr),
    .req_ready (req_ready),
    .pa        (pa_o),
    .mark_en   (mark_en),
    .mark_vpn  (mark_vpn),
    .fault     (fault_o),
    .fault_vpn (fault_vpn_o),
    .fault_dadr(fault_dadr_o)
  );
endmodule

// File: rtl/page_map_xlate_chk.sv
module page_map_xlate_chk #(
  parameter int VPN_W = 4,
  parameter int OFF_W = 8,
  parameter int PPN_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [VPN_W+OFF_W-1:0] req_va,
  input logic                   req_store,
  input logic [PPN_W+OFF_W-1:0] pa_o,
  input logic                   fault_o,
  input logic [VPN_W-1:0]       fault_vpn_o,
  input logic                   upd_en,
  input logic [VPN_W-1:0]       upd_vpn,
  input logic                   upd_resident,
  input logic                   upd_dirty,
  input logic [(1<<VPN_W)-1:0]  resident_vec,
  input logic [(1<<VPN_W)-1:0]  dirty_vec
);
  localparam int VA_W = VPN_W + OFF_W;
  logic [VPN_W-1:0] vpn;
  assign vpn = req_va[VA_W-1:OFF_W];

  assert_miss_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> fault_o);

  assert_fault_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (fault_vpn_o == $past(vpn)));

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (pa_o[OFF_W-1:0] == req_va[OFF_W-1:0]));

  assert_hit_resident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> resident_vec[vpn]);

  assert_store_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_store && !(upd_en && upd_vpn == vpn))
      |=> dirty_vec[$past(vpn)]);

  assert_fault_no_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !upd_en)
      |=> (dirty_vec[$past(vpn)] == $past(dirty_vec[vpn])));

  assert_update_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (resident_vec[$past(upd_vpn)] == $past(upd_resident)));

  assert_update_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (dirty_vec[$past(upd_vpn)] == $past(upd_dirty)));

  assert_fault_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !fault_o);
endmodule

bind page_map_xlate page_map_xlate_chk #(
  .VPN_W(VPN_W),
  .OFF_W(OFF_W),
  .PPN_W(PPN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_va      (req_va),
  .req_store   (req_store),
  .pa_o        (pa_o),
  .fault_o     (fault_o),
  .fault_vpn_o (fault_vpn_o),
  .upd_en      (upd_en),
  .upd_vpn     (upd_vpn),
  .upd_resident(upd_resident),
  .upd_dirty   (upd_dirty),
  .resident_vec(resident_vec),
  .dirty_vec   (dirty_vec)
);

// File: tb/page_map_xlate_bench.sv
module page_map_xlate_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_va = '0;
  logic        req_store = 1'b0;
  logic [10:0] pa_o;
  logic        fault_o;
  logic [3:0]  fault_vpn_o;
  logic [15:0] fault_dadr_o;
  logic        upd_en = 1'b0;
  logic [3:0]  upd_vpn = '0;
  logic        upd_resident = 1'b0;
  logic        upd_dirty = 1'b0;
  logic [2:0]  upd_ppn = '0;
  logic [15:0] upd_dadr = '0;
  logic [3:0]  insp_vpn = '0;
  logic        insp_resident;
  logic        insp_dirty;
  logic [2:0]  insp_ppn;
  logic [15:0] insp_dadr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [10:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  page_map_xlate u_page_map_xlate (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic upd_set(input logic [3:0] v, input logic r, input logic d,
                         input logic [2:0] p, input logic [15:0] a);
    upd_en = 1'b1; upd_vpn = v; upd_resident = r; upd_dirty = d;
    upd_ppn = p; upd_dadr = a;
  endtask

  task automatic upd(input logic [3:0] v, input logic r, input logic d,
                     input logic [2:0] p, input logic [15:0] a);
    tick();
    upd_set(v, r, d, p, a);
    tick();
    upd_en = 1'b0;
  endtask

  task automatic look(input logic [3:0] v);
    insp_vpn = v;
    #1;
  endtask

  // driver: one accepted access, expected address queued for the monitor
  task automatic hit_access(input logic [11:0] va, input bit st,
                            input logic [10:0] exp_pa);
    exp_q.push_back(exp_pa);
    tick();
    req_valid = 1'b1; req_va = va; req_store = st;
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 ready on resident page", req_ready, 1);
    tick();
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  // monitor: compares every accepted translation against the queue
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected acceptance", pa_o, 0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(pa_o == e, "R3 physical address", pa_o, e);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset contents
    chk(fault_o == 1'b0, "R1 fault after reset", fault_o, 0);
    for (int i = 0; i < 16; i++) begin
      look(4'(i));
      chk({insp_resident, insp_dirty, insp_ppn, insp_dadr} == '0,
          "R1 entry cleared", {insp_resident, insp_dirty, insp_ppn, insp_dadr}, 0);
    end

    // R2/R6/R8: faulting store, update while pending, retry
    upd(4'h6, 1'b0, 1'b0, 3'd0, 16'hA600);
    tick();
    req_valid = 1'b1; req_va = 12'h600; req_store = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R2 held off", req_ready, 0);
    tick();
    @(negedge clk);
    chk(fault_o == 1'b1, "R2 fault raised", fault_o, 1);
    chk(fault_vpn_o == 4'h6, "R2 fault page", fault_vpn_o, 6);
    chk(fault_dadr_o == 16'hA600, "R2 fault storage", fault_dadr_o, 16'hA600);
    tick();
    upd_set(4'h6, 1'b1, 1'b0, 3'd5, 16'hA600);
    exp_q.push_back(11'h500);
    @(negedge clk);
    chk(req_ready == 1'b0, "R6 old entry seen in update cycle", req_ready, 0);
    tick();
    upd_en = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 retry accepted", req_ready, 1);
    tick();
    req_valid = 1'b0; req_store = 1'b0;
    @(negedge clk);
    chk(fault_o == 1'b0, "R8 fault cleared", fault_o, 0);
    look(4'h6);
    chk(insp_dirty == 1'b1, "R4 retried store marks dirty", insp_dirty, 1);
    chk(insp_ppn == 3'd5, "R6 frame written", insp_ppn, 5);

    // R3: several mappings and offsets
    upd(4'h0, 1'b1, 1'b0, 3'd3, 16'h1000);
    upd(4'hF, 1'b1, 1'b0, 3'd7, 16'h1F00);
    hit_access(12'h000, 1'b0, 11'h300);
    hit_access(12'hFFF, 1'b0, 11'h7FF);
    hit_access(12'h0A5, 1'b0, 11'h3A5);
    hit_access(12'h6AB, 1'b0, 11'h5AB);
    @(negedge clk);
    look(4'h0);
    chk(insp_dirty == 1'b0, "R4 load leaves clean", insp_dirty, 0);

    // R5: faulting store on page E
    tick();
    req_valid = 1'b1; req_va = 12'hE12; req_store = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R2 page E held off", req_ready, 0);
    tick();
    req_valid = 1'b0; req_store = 1'b0;
    @(negedge clk);
    chk(fault_vpn_o == 4'hE, "R2 page E fault", fault_vpn_o, 14);
    look(4'hE);
    chk(insp_dirty == 1'b0, "R5 faulted store no mark", insp_dirty, 0);
    tick();
    @(negedge clk);
    chk(fault_o == 1'b0, "R8 fault drops when idle", fault_o, 0);

    // R7: update and store on the same entry in one cycle
    upd(4'h3, 1'b1, 1'b0, 3'd2, 16'hB000);
    exp_q.push_back(11'h2C4);
    tick();
    req_valid = 1'b1; req_va = 12'h3C4; req_store = 1'b1;
    upd_set(4'h3, 1'b1, 1'b0, 3'd7, 16'hB300);
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 old mapping used", req_ready, 1);
    tick();
    req_valid = 1'b0; req_store = 1'b0; upd_en = 1'b0;
    @(negedge clk);
    look(4'h3);
    chk(insp_dirty == 1'b0, "R7 update wins dirty", insp_dirty, 0);
    chk(insp_ppn == 3'd7, "R7 update frame", insp_ppn, 7);
    chk(insp_dadr == 16'hB300, "R6 storage written", insp_dadr, 16'hB300);
    hit_access(12'h3C4, 1'b0, 11'h7C4);

    // R9: update and store on different entries in one cycle
    exp_q.push_back(11'h710);
    tick();
    req_valid = 1'b1; req_va = 12'h310; req_store = 1'b1;
    upd_set(4'h9, 1'b1, 1'b1, 3'd4, 16'h9900);
    tick();
    req_valid = 1'b0; req_store = 1'b0; upd_en = 1'b0;
    @(negedge clk);
    look(4'h3);
    chk(insp_dirty == 1'b1, "R9 store mark kept", insp_dirty, 1);
    look(4'h9);
    chk({insp_resident, insp_dirty, insp_ppn} == 5'b11100, "R9 update kept",
        {insp_resident, insp_dirty, insp_ppn}, 5'b11100);

    // R2: evicted page faults again
    upd(4'h6, 1'b0, 1'b0, 3'd5, 16'hA600);
    tick();
    req_valid = 1'b1; req_va = 12'h6FF; req_store = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R2 evicted page held off", req_ready, 0);
    tick();
    req_valid = 1'b0;
    @(negedge clk);
    chk(fault_o == 1'b1, "R2 evicted page fault", fault_o, 1);
    chk(exp_q.size() == 0, "R3 all expected accepted", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule